// File: doc/BRIEF.md
# MDIO management frame master

This block runs single register accesses on a PHY management bus made of a clock line (MDC) and a shared bidirectional data line (MDIO). The host places the access type, a PHY address, a register address and, for writes, the data word on its inputs and pulses a start strobe. The block then emits one complete frame and reports the result with a one-cycle completion pulse. For reads, that result is the 16-bit word returned by the PHY and an error flag.

MDC comes from a programmable half-period divider on the system clock. Every frame begins with a run of logic-one bits. Data leaving the master changes only while MDC is low. On reads, the master hands the data line to the PHY through an output-enable meant for a tri-state pad. It then checks that the PHY pulled the line low during turnaround. If no PHY answered, it flags an error and returns zero. Between frames MDC rests low and the master drives the line high.

Top module: `mdio_frame_master`

## Requirements
- R1: Out of reset and whenever busy is low, mdc_o is 0, mdo_oe_o is 1 and mdo_o is 1.
- R2: Each frame starts with PRE_LEN (default 32) MDC clocks during which mdo_o is 1 and mdo_oe_o is 1.
- R3: After the preamble, 14 bits are sent MSB first, one per MDC clock: start code 01, opcode (10 = read when rd_wr_n_i is 1, 01 = write), the 5-bit PHY address, then the 5-bit register address.
- R4: MDC high and low phases each last HALF_DIV system clocks, and mdo_o never changes while mdc_o is high.
- R5: On a write, the register address is followed by the turnaround bits 10 and then the 16 write data bits MSB first, all driven (mdo_oe_o 1) for the whole frame.
- R6: On a read, mdo_oe_o drops to 0 at the start of the clock that follows the register address and stays 0 for the remaining 18 clocks. It returns to 1 when the frame ends. mdo_oe_o only changes while mdc_o is low.
- R7: On a read, the 16 data bits are taken MSB first from mdi_i just before the rising MDC edges of the last 16 clocks (clocks 49 to 64 with the default preamble). They appear on rdata_o when done_o pulses.
- R8: On a read, mdi_i is sampled just before the rising MDC edge of the second turnaround clock (clock 48). If it is high, err_o is 1 and rdata_o is 0 at done_o. Otherwise err_o is 0. Writes give err_o 0 and rdata_o 0.
- R9: busy_o rises the cycle after an accepted start and falls on the cycle done_o pulses for one cycle. Each frame has exactly PRE_LEN+32 MDC clocks.
- R10: start_i is ignored while busy_o is 1, so the frame in progress and the number of completions are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| rd_wr_n_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | ADDR_W | Target PHY address |
| reg_addr_i | input | ADDR_W | Target register address |
| wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read result, zero on error or write |
| err_o | output | 1 | No PHY response during read turnaround |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Data toward the pad |
| mdo_oe_o | output | 1 | Pad output enable |
| mdi_i | input | 1 | Data from the pad |

## Verification
Writes are issued with all-zero, all-one and alternating address and data fields. These show whether each header and data bit lands in its own MDC clock in the right order. Reads run against a modelled PHY that returns mixed, all-zero and all-one words, which exposes bit order and off-by-one sampling of the data window. Two further reads leave the turnaround line high, one of them with a nonzero data pattern, which separates a forced-zero result from one merely captured as zero. One read follows an error to show that the flag clears. A start strobe injected mid-frame shows that the frame in progress and the completion count are untouched.

// File: rtl/mdio_fm_pkg.sv
package mdio_fm_pkg;
   localparam logic [1:0] SOF_CODE = 2'b01;
   localparam logic [1:0] OPC_RD   = 2'b10;
   localparam logic [1:0] OPC_WR   = 2'b01;
   localparam logic [1:0] TA_WR    = 2'b10;
   localparam int unsigned CTL_BITS = 4;
   localparam int unsigned TA_BITS  = 2;
endpackage

// File: rtl/mdio_fm_tick.sv
module mdio_fm_tick #(
   parameter int unsigned HALF = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic tick_o
);
   localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap   = (cnt_q == CW'(HALF - 1));
   assign tick_o = run_i && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr_i || !run_i) cnt_q <= '0;
      else if (wrap)           cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // R4: half-period ticks never come back to back
   p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/mdio_fm_txsr.sv
module mdio_fm_txsr #(
   parameter int unsigned W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         shift_i,
   output logic         bit_o
);
   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '1;
      else if (load_i)  sr_q <= load_val_i;
      else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b1};
   end

   assign bit_o = sr_q[W-1];
endmodule

// File: rtl/mdio_fm_rxcap.sv
module mdio_fm_rxcap #(
   parameter int unsigned DW   = 16,
   parameter int unsigned SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          smp_i,
   input  logic          err_slot_i,
   input  logic          mdi_i,
   output logic [DW-1:0] data_o,
   output logic          err_o
);
   logic mdi_s;

   generate
      if (SYNC == 0) begin : g_nosync
         assign mdi_s = mdi_i;
      end else begin : g_sync
         logic [SYNC:0] chain;
         assign chain[0] = mdi_i;
         for (genvar g = 0; g < SYNC; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g+1] <= 1'b1;
               else        chain[g+1] <= chain[g];
            end
         end
         assign mdi_s = chain[SYNC];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         err_o  <= 1'b0;
      end else if (clr_i) begin
         data_o <= '0;
         err_o  <= 1'b0;
      end else if (smp_i) begin
         if (err_slot_i) err_o  <= mdi_s;
         else            data_o <= {data_o[DW-2:0], mdi_s};
      end
   end

   // R8: the error flag moves only on its own sample or a clear
   p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !(smp_i && err_slot_i)) |=> $stable(err_o));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
   parameter int unsigned HALF_DIV    = 10,
   parameter int unsigned PRE_LEN     = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rd_wr_n_i,
   input  logic [ADDR_W-1:0] phy_addr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              err_o,
   output logic              mdc_o,
   output logic              mdo_o,
   output logic              mdo_oe_o,
   input  logic              mdi_i
);
   import mdio_fm_pkg::*;

   localparam int unsigned HDR_W   = CTL_BITS + 2 * ADDR_W;
   localparam int unsigned FRAME_W = PRE_LEN + HDR_W + TA_BITS + DATA_W;
   localparam int unsigned SLOT_W  = $clog2(FRAME_W);
   localparam logic [SLOT_W-1:0] TA_SLOT   = SLOT_W'(PRE_LEN + HDR_W);
   localparam logic [SLOT_W-1:0] ERR_SLOT  = SLOT_W'(PRE_LEN + HDR_W + 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_W - 1);

   generate
      if (HALF_DIV < 2)   begin : g_chk_div  $error("HALF_DIV must be 2 or more"); end
      if (PRE_LEN < 1)    begin : g_chk_pre  $error("PRE_LEN must be at least 1"); end
      if (ADDR_W != 5)    begin : g_chk_addr $error("ADDR_W is fixed at 5 by the frame"); end
      if (DATA_W != 16)   begin : g_chk_data $error("DATA_W is fixed at 16 by the frame"); end
      if (SYNC_STAGES > 3) begin : g_chk_sync $error("SYNC_STAGES above 3 is not useful"); end
   endgenerate

   logic              busy_q, mdc_q, rd_q, oe_q, done_q, err_q;
   logic [DATA_W-1:0] rdata_q;
   logic [SLOT_W-1:0] slot_q;
   logic              tick, start_acc, rise_ev, fall_ev, last_fall;
   logic [FRAME_W-1:0] frame_val;
   logic [DATA_W-1:0] cap_data;
   logic              cap_err, smp, tx_bit;

   assign start_acc = start_i && !busy_q;
   assign rise_ev   = tick && !mdc_q;
   assign fall_ev   = tick && mdc_q;
   assign last_fall = fall_ev && (slot_q == LAST_SLOT);

   assign frame_val = {{PRE_LEN{1'b1}}, SOF_CODE,
                       (rd_wr_n_i ? OPC_RD : OPC_WR),
                       phy_addr_i, reg_addr_i,
                       (rd_wr_n_i ? 2'b11 : TA_WR),
                       (rd_wr_n_i ? {DATA_W{1'b1}} : wdata_i)};

   mdio_fm_tick #(.HALF(HALF_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (start_acc),
      .run_i  (busy_q),
      .tick_o (tick)
   );

   mdio_fm_txsr #(.W(FRAME_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start_acc),
      .load_val_i (frame_val),
      .shift_i    (fall_ev),
      .bit_o      (tx_bit)
   );

   assign smp = rise_ev && rd_q && (slot_q >= ERR_SLOT);

   mdio_fm_rxcap #(.DW(DATA_W), .SYNC(SYNC_STAGES)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (start_acc),
      .smp_i      (smp),
      .err_slot_i (slot_q == ERR_SLOT),
      .mdi_i      (mdi_i),
      .data_o     (cap_data),
      .err_o      (cap_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         mdc_q   <= 1'b0;
         rd_q    <= 1'b0;
         oe_q    <= 1'b1;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
         slot_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_acc) begin
            busy_q <= 1'b1;
            mdc_q  <= 1'b0;
            rd_q   <= rd_wr_n_i;
            oe_q   <= 1'b1;
            slot_q <= '0;
         end else if (rise_ev) begin
            mdc_q <= 1'b1;
         end else if (fall_ev) begin
            mdc_q <= 1'b0;
            if (last_fall) begin
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               oe_q    <= 1'b1;
               err_q   <= rd_q && cap_err;
               rdata_q <= (rd_q && !cap_err) ? cap_data : '0;
            end else begin
               slot_q <= slot_q + 1'b1;
               if (rd_q && (slot_q + 1'b1 == TA_SLOT)) oe_q <= 1'b0;
            end
         end
      end
   end

   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign rdata_o  = rdata_q;
   assign err_o    = err_q;
   assign mdc_o    = mdc_q;
   assign mdo_o    = tx_bit;
   assign mdo_oe_o = oe_q;

   // R1: idle bus state
   p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mdc_o && mdo_oe_o && mdo_o));
   // R4: outgoing data holds while MDC is high
   p_mdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mdc_o |-> $stable(mdo_o));
   // R6: direction flips only with MDC low
   p_oe_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(mdo_oe_o) |-> !mdc_o);
   // R8: an error always comes with zero data
   p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (rdata_o == '0));
   // R9: completion is a single-cycle pulse with busy released
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R10: a strobe during a frame cannot end or restart it early
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/sim_mdio_frame_master.sv
module sim_mdio_frame_master;
   localparam int unsigned HALF = 10;
   localparam int unsigned NSLOT = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, rdw = 1'b0, mdi = 1'b1;
   logic [4:0] phy = '0, rga = '0;
   logic [15:0] wd = '0;
   logic busy, done, err, mdc, mdo, oe;
   logic [15:0] rdata;

   always #10 clk = ~clk;

   mdio_frame_master u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .rd_wr_n_i(rdw),
      .phy_addr_i(phy), .reg_addr_i(rga), .wdata_i(wd),
      .busy_o(busy), .done_o(done), .rdata_o(rdata), .err_o(err),
      .mdc_o(mdc), .mdo_o(mdo), .mdo_oe_o(oe), .mdi_i(mdi)
   );

   typedef struct {
      bit          rd;
      logic [4:0]  phy;
      logic [4:0]  rg;
      logic [15:0] wd;
      bit          ta_low;
      logic [15:0] pd;
   } item_t;

   item_t sb[$];
   int nchk = 0, nfail = 0, ndone = 0, npush = 0;
   int edge_cnt = 0, period_bad = 0;
   bit ended = 0;
   logic cap_mdo [NSLOT];
   logic cap_oe [NSLOT];
   bit cur_ta_low = 1;
   logic [15:0] cur_pd = '1;
   realtime last_rise = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
              (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
   endfunction

   // PHY model: records the bus at each rising MDC edge, then sets up the next bit
   initial begin
      forever begin
         @(posedge mdc);
         if (edge_cnt > 0 && ($realtime - last_rise) != real'(2 * HALF * 20)) period_bad++;
         last_rise = $realtime;
         if (edge_cnt < NSLOT) begin
            cap_mdo[edge_cnt] = mdo;
            cap_oe[edge_cnt]  = oe;
         end
         edge_cnt++;
         if (edge_cnt == 47)                          mdi = cur_ta_low ? 1'b0 : 1'b1;
         else if (edge_cnt >= 48 && edge_cnt < 64)    mdi = cur_pd[63 - edge_cnt];
         else                                         mdi = 1'b1;
      end
   end

   // Scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            item_t it;
            logic [63:0] ef, got;
            logic [15:0] er;
            bit pre_ok = 1, hdr_ok = 1, tail_ok = 1, oe_ok = 1;
            ndone++;
            if (sb.size() == 0) begin
               chk(0, "R10", "unexpected completion", 64'(ndone), 64'(npush));
            end else begin
               it = sb.pop_front();
               ef = exp_frame(it.rd, it.phy, it.rg, it.wd);
               got = '0;
               for (int s = 0; s < NSLOT; s++) begin
                  got[63 - s] = cap_mdo[s];
                  if (s < 32 && cap_mdo[s] !== 1'b1) pre_ok = 0;
                  if (s >= 32 && s < 46 && cap_mdo[s] !== ef[63 - s]) hdr_ok = 0;
                  if (!it.rd && s >= 46 && cap_mdo[s] !== ef[63 - s]) tail_ok = 0;
                  if (cap_oe[s] !== ((it.rd && s >= 46) ? 1'b0 : 1'b1)) oe_ok = 0;
               end
               chk(pre_ok, "R2", "preamble bits", got, ef);
               chk(hdr_ok, "R3", "start/opcode/address bits", got, ef);
               if (!it.rd) chk(tail_ok, "R5", "turnaround and write data", got, ef);
               chk(oe_ok, "R6", "output-enable per clock", 64'(it.rd), 64'(it.rd));
               er = (it.rd && it.ta_low) ? it.pd : 16'h0000;
               chk(rdata === er, "R7", "read data", 64'(rdata), 64'(er));
               chk(err === (it.rd && !it.ta_low), "R8", "error flag",
                   64'(err), 64'(it.rd && !it.ta_low));
               chk(edge_cnt == NSLOT, "R9", "MDC clocks per frame", 64'(edge_cnt), 64'(NSLOT));
               chk(!busy && !mdc && oe && mdo, "R1", "bus idle at completion",
                   {60'd0, busy, mdc, oe, mdo}, 64'h3);
            end
         end
      end
   end

   task automatic do_txn(input bit rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input bit ta_low, input logic [15:0] pd,
                         input bit poke);
      item_t it;
      @(negedge clk);
      while (busy) @(negedge clk);
      it.rd = rd; it.phy = p; it.rg = r; it.wd = d; it.ta_low = ta_low; it.pd = pd;
      sb.push_back(it);
      npush++;
      cur_ta_low = ta_low;
      cur_pd = pd;
      edge_cnt = 0;
      rdw = rd; phy = p; rga = r; wd = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
      if (poke) begin
         repeat (300) @(negedge clk);
         rdw = ~rd; phy = ~p; rga = ~r; wd = ~d; start = 1'b1; // R10 stray strobe
         @(negedge clk);
         start = 1'b0;
         rdw = rd; phy = p; rga = r; wd = d;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         nchk++; nfail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !mdc && oe && mdo && !done, "R1", "reset bus state",
          {59'd0, busy, mdc, oe, mdo, done}, 64'h6);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!mdc && oe && mdo, "R1", "idle after reset", {61'd0, mdc, oe, mdo}, 64'h3);

      do_txn(0, 5'h1F, 5'h15, 16'hA55A, 1, 16'hFFFF, 0);
      do_txn(0, 5'h00, 5'h00, 16'h0000, 1, 16'hFFFF, 0);
      do_txn(0, 5'h1F, 5'h1F, 16'hFFFF, 1, 16'hFFFF, 0);
      do_txn(1, 5'h03, 5'h02, 16'h0000, 1, 16'hBEEF, 0);
      do_txn(1, 5'h0A, 5'h15, 16'h0000, 1, 16'h0000, 0);
      do_txn(1, 5'h15, 5'h0A, 16'h0000, 1, 16'hFFFF, 0);
      do_txn(1, 5'h01, 5'h01, 16'h0000, 0, 16'hFFFF, 0);
      do_txn(1, 5'h02, 5'h04, 16'h0000, 0, 16'h1234, 0);
      do_txn(1, 5'h02, 5'h04, 16'h0000, 1, 16'h8001, 0);
      do_txn(0, 5'h11, 5'h0E, 16'h3C96, 1, 16'hFFFF, 1);

      repeat (50) @(negedge clk);
      chk(period_bad == 0, "R4", "MDC rise-to-rise spacing", 64'(period_bad), 64'd0);
      chk(ndone == npush, "R10", "completions per accepted start", 64'(ndone), 64'(npush));
      chk(sb.size() == 0, "R10", "scoreboard drained", 64'(sb.size()), 64'd0);
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule